// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the address for each beat of a four-beat burst on a synchronous burst memory. When a burst starts, the full external address is captured and presented as the first beat. The following beats are produced internally: the upper address bits are kept exactly as captured, and only the two lowest bits move, walking through all four addresses of the aligned four-word block that holds the start address.

A mode input picks the visiting order. With mode high, the low bits are the starting low bits XOR a beat count. With mode low, the low bits are the starting low bits plus the beat count, wrapping modulo four. An active-low advance input steps to the next beat. Holding advance high with no new start keeps the current address, which gives a wait cycle. The beat count wraps after the fourth beat, so continued advancing cycles through the same four addresses. A start always wins over advance. The mode is sampled at every clock edge and takes effect at the next step.

Top module: `burst_addr_gen`

## Requirements
- R1: During a burst (no start), addr_o[ADDR_W-1:2] keeps the value captured at the last start.
- R2: With mode_i = 1 at a stepping edge, the low bits after that edge equal start_low XOR k, where k is the beat count after the step (0 at start, +1 per step, modulo 4); for a start of 01 this gives 01, 00, 11, 10.
- R3: With mode_i = 0 at a stepping edge, the low bits after that edge equal (start_low + k) modulo 4; for a start of 10 this gives 10, 11, 00, 01.
- R4: After a clock edge with start_i = 1, addr_o equals the addr_i value sampled at that edge.
- R5: The address steps only at an edge with start_i = 0 and adv_n_i = 0, and the new address appears after that edge.
- R6: At an edge with start_i = 0 and adv_n_i = 1, addr_o keeps its value whatever mode_i is.
- R7: After the fourth beat, further steps continue the same cyclic sequence (the count wraps from 3 to 0).
- R8: start_i = 1 overrides adv_n_i = 0, reloads the address and resets the beat count to 0.
- R9: mode_i is sampled at each stepping edge; changing it mid-burst changes only the steps taken after the change, relative to the original start low bits and the running count.
- R10: While rst_n = 0, addr_o is 0 after each clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a new burst from addr_i |
| addr_i | input | ADDR_W | External start address |
| adv_n_i | input | 1 | Active-low advance to next beat |
| mode_i | input | 1 | Order: 1 interleaved, 0 linear |
| addr_o | output | ADDR_W | Current beat address |

## Verification
The order logic is driven from a start of 01 in interleaved mode and from a start of 10 in linear mode, two starts whose sequences differ in every non-initial beat, so a swapped or mis-wired order is told apart from a correct one. A start of 11 next to an all-ones upper field shows that the low-bit wrap never carries into the upper bits. Wait cycles with mode toggling, a start asserted together with advance, and a mode switch mid-burst separate the hold, priority and per-step mode sampling behaviour from plain stepping.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } order_e;

endpackage

// File: rtl/burst_count.sv
module burst_count #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] cnt_d_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (restart_i) begin
            state_d.cnt = '0;
        end else if (step_i) begin
            state_d.cnt = state_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_q_o = state_q.cnt;
    assign cnt_d_o = state_d.cnt;

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !restart_i) |=> (cnt_q_o == CNT_W'($past(cnt_q_o) + 1'b1))); // R7

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q_o == '0)); // R8

endmodule

// File: rtl/burst_order_calc.sv
module burst_order_calc
    import burst_addr_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] start_low_i,
    input  logic [CNT_W-1:0] count_i,
    input  order_e           order_i,
    output logic [CNT_W-1:0] low_o
);

    logic [CNT_W-1:0] xor_low;
    logic [CNT_W-1:0] sum_low;

    for (genvar g = 0; g < CNT_W; g++) begin : g_xor_lane
        assign xor_low[g] = start_low_i[g] ^ count_i[g];
    end

    assign sum_low = start_low_i + count_i;

    always_comb begin
        case (order_i)
            ORDER_INTERLEAVED: low_o = xor_low;
            default:           low_o = sum_low;
        endcase
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              adv_n_i,
    input  logic              mode_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int UPPER_W = ADDR_W - CNT_W;

    typedef struct packed {
        logic [UPPER_W-1:0] upper;
        logic [CNT_W-1:0]   start_low;
        logic [CNT_W-1:0]   cur_low;
    } gen_state_t;

    gen_state_t       state_d, state_q;
    logic             restart;
    logic             step;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] calc_low;
    order_e           order;

    assign restart = start_i;
    assign step    = !start_i && !adv_n_i;
    assign order   = order_e'(mode_i);

    burst_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .step_i    (step),
        .cnt_q_o   (cnt_q),
        .cnt_d_o   (cnt_d)
    );

    burst_order_calc #(
        .CNT_W (CNT_W)
    ) u_order (
        .start_low_i (state_q.start_low),
        .count_i     (cnt_d),
        .order_i     (order),
        .low_o       (calc_low)
    );

    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d.upper     = addr_i[ADDR_W-1:CNT_W];
            state_d.start_low = addr_i[CNT_W-1:0];
            state_d.cur_low   = addr_i[CNT_W-1:0];
        end else if (step) begin
            state_d.cur_low   = calc_low;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign addr_o = {state_q.upper, state_q.cur_low};

    AST_LOAD_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (addr_o == $past(addr_i))); // R4

    AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(addr_o[ADDR_W-1:CNT_W])); // R1

    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && adv_n_i) |=> $stable(addr_o)); // R6

    AST_INTERLEAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode_i) |=> ((addr_o[CNT_W-1:0] ^ state_q.start_low) == cnt_q)); // R2

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !mode_i) |=> (CNT_W'(addr_o[CNT_W-1:0] - state_q.start_low) == cnt_q)); // R3

endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

    localparam int ADDR_W = 18;
    localparam int VEC_W  = 3 + 2 * ADDR_W;
    localparam int NVEC   = 16;

    // fields: start, adv_n, mode, addr_in, expected addr_o
    localparam logic [VEC_W-1:0] VECS [NVEC] = '{
        {1'b1, 1'b0, 1'b1, 18'h12345, 18'h12345},  // R4 R8 load with advance asserted
        {1'b0, 1'b0, 1'b1, 18'h00000, 18'h12344},  // R2 beat 2
        {1'b0, 1'b0, 1'b1, 18'h00000, 18'h12347},  // R2 beat 3
        {1'b0, 1'b1, 1'b1, 18'h3FFFF, 18'h12347},  // R6 wait
        {1'b0, 1'b0, 1'b1, 18'h00000, 18'h12346},  // R2 beat 4
        {1'b0, 1'b0, 1'b1, 18'h00000, 18'h12345},  // R7 wrap
        {1'b0, 1'b0, 1'b1, 18'h00000, 18'h12344},  // R7 continue
        {1'b1, 1'b0, 1'b0, 18'h2ABCE, 18'h2ABCE},  // R4 load linear
        {1'b0, 1'b0, 1'b0, 18'h00000, 18'h2ABCF},  // R3
        {1'b0, 1'b0, 1'b0, 18'h00000, 18'h2ABCC},  // R3
        {1'b0, 1'b0, 1'b0, 18'h00000, 18'h2ABCD},  // R3
        {1'b0, 1'b0, 1'b0, 18'h00000, 18'h2ABCE},  // R7 wrap linear
        {1'b1, 1'b1, 1'b0, 18'h3FFFF, 18'h3FFFF},  // R4 all ones
        {1'b0, 1'b0, 1'b0, 18'h00000, 18'h3FFFC},  // R1 no carry upward
        {1'b0, 1'b0, 1'b0, 18'h00000, 18'h3FFFD},  // R1
        {1'b0, 1'b0, 1'b1, 18'h00000, 18'h3FFFC}   // R9 mode switch
    };

    logic              clk;
    logic              rst_n;
    logic              start_i;
    logic [ADDR_W-1:0] addr_i;
    logic              adv_n_i;
    logic              mode_i;
    logic [ADDR_W-1:0] addr_o;

    int errors;
    int checks;
    int cycles;

    burst_addr_gen #(
        .ADDR_W (ADDR_W),
        .CNT_W  (2)
    ) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .addr_i  (addr_i),
        .adv_n_i (adv_n_i),
        .mode_i  (mode_i),
        .addr_o  (addr_o)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [ADDR_W-1:0] exp);
        checks++;
        if (addr_o !== exp) begin
            errors++;
            $display("FAIL %s: addr_o=%h expected=%h", req, addr_o, exp);
        end
    endtask

    task automatic step_cycle(input logic st, input logic [ADDR_W-1:0] a,
                              input logic adv_n, input logic md);
        @(negedge clk);
        start_i = st;
        addr_i  = a;
        adv_n_i = adv_n;
        mode_i  = md;
        @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: cycles=%0d expected=<5000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        errors  = 0;
        checks  = 0;
        cycles  = 0;
        rst_n   = 1'b0;
        start_i = 1'b1;
        addr_i  = 18'h2AAAA;
        adv_n_i = 1'b0;
        mode_i  = 1'b1;

        // R10: reset clears output even with start and advance driven
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset", '0);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            step_cycle(VECS[i][VEC_W-1], VECS[i][2*ADDR_W-1:ADDR_W],
                       VECS[i][VEC_W-2], VECS[i][VEC_W-3]);
            check($sformatf("R1-table vec %0d (R2/R3/R4/R6/R7/R9)", i), VECS[i][ADDR_W-1:0]);
        end

        // R9: back to linear at count 0 -> 11 + 0 = 11
        step_cycle(1'b0, '0, 1'b0, 1'b0);
        check("R9 mode back to linear", 18'h3FFFF);

        // R5/R6: several wait cycles with mode and addr_i toggling
        step_cycle(1'b1, 18'h00C41, 1'b1, 1'b0);
        check("R4 load for wait test", 18'h00C41);
        for (int k = 0; k < 4; k++) begin
            step_cycle(1'b0, 18'h3F00F, 1'b1, k[0]);
            check("R6 wait holds", 18'h00C41);
        end
        step_cycle(1'b0, 18'h3F00F, 1'b0, 1'b0);
        check("R5 step after waits", 18'h00C42);

        // R8: start mid-burst with advance low restarts count
        step_cycle(1'b1, 18'h1F0F2, 1'b0, 1'b1);
        check("R8 restart mid-burst", 18'h1F0F2);
        step_cycle(1'b0, '0, 1'b0, 1'b1);
        check("R8 count restarted (10^01)", 18'h1F0F3);

        // R10: reset mid-burst
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R10 reset mid-burst", '0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule